// File: doc/BRIEF.md
# Byte-Packing Transfer Buffer

This block is the data staging store between a 16-bit register port and a byte-serial line engine. Software pushes halfwords, or one trailing single byte, into a small shift buffer. The engine pulls those bytes out one at a time, starting with the oldest. In the other direction, the engine deposits received bytes and software drains them two at a time as halfwords. One input selects whether the first byte on the line maps to the high or the low half of the software word.

The store is shared by both directions. It has its own transmit count and its own receive count, and each count is limited to `BYTES` (default 4). The block does not hold status bits. For every access it raises one-cycle event pulses that tell an outer status register which flags to set or clear. These cover transmit underflow, transmit ready, receive overrun, receive ready and single-byte data.

All event outputs and the `txByte`/`rdData` values are combinational from the current state and the strobes. Counts and buffer contents change at the next rising clock edge.

Top module: `pack_buf`

## Requirements
- R1: After reset both counts are zero, the buffer holds zero, `txByte` and `rdData` read 0, and no event output is high while no strobe is asserted.
- R2: A `wrHalf` access is ignored, with no state change and no event, when more than `BYTES-2` transmit bytes are pending. Otherwise the buffer shifts up by 16 bits, the new halfword enters the low 16 bits and the transmit count rises by 2. With `bigEnd`=0 the bytes are swapped on entry (`wrData[7:0]` goes to bits 15:8). With `bigEnd`=1 the halfword is stored as written.
- R3: A `wrByte` access follows the same acceptance rule. It shifts the buffer up by 8 bits, places `wrData[7:0]` in bits 7:0 and raises the transmit count by 1.
- R4: `txByte` is byte lane (transmit count − 1), where lane k is bits 8k+7:8k, or 0 when nothing is pending. `txTake` with bytes pending lowers the count by 1. The net effect is that bytes leave in write order, a halfword leaves low byte first when `bigEnd`=0 and high byte first when `bigEnd`=1, and a trailing byte leaves last.
- R5: Every `txTake` pulses `txRdySet`. A `txTake` with no transmit byte pending also pulses `txUdfSet` and changes no count.
- R6: An accepted write pulses `txUdfClr`. It also pulses `txRdyClr` when more than 2 transmit bytes are pending after the write.
- R7: `rxPut` writes `rxByte` into lane (receive count) and raises the count, so bytes fill upward from lane 0. With `BYTES` already held, the byte is dropped and `rxOvrSet` pulses. Every `rxPut` pulses `rxRdySet`.
- R8: `rdHalf` returns `{lane1,lane0}` when `bigEnd`=0 and `{lane0,lane1}` when `bigEnd`=1. If 1 byte was held, `sbdSet` pulses and the count becomes 0. If 2 were held, the count becomes 0. If more than 2 were held, the buffer shifts down 16 bits and the count falls by 2.
- R9: Every `rdHalf` pulses `rxOvrClr`. It also pulses `rxRdyClr` when the receive count after the read is 0.
- R10: `startClr` zeroes the buffer and both counts.
- R11: Only one access takes effect per cycle, in the priority order `startClr`, `wrHalf`, `wrByte`, `rdHalf`, `txTake`, `rxPut`. A lower-priority strobe in the same cycle has no effect and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bigEnd | input | 1 | Byte order select for software words |
| startClr | input | 1 | Clear buffer and counts (new transfer start) |
| wrHalf | input | 1 | 16-bit software write strobe |
| wrByte | input | 1 | 8-bit software write strobe |
| wrData | input | 16 | Software write data |
| rdHalf | input | 1 | Software read strobe |
| rdData | output | 16 | Software read data |
| txTake | input | 1 | Engine consumes one transmit byte |
| txByte | output | 8 | Next transmit byte |
| rxPut | input | 1 | Engine delivers one received byte |
| rxByte | input | 8 | Received byte |
| txUdfSet | output | 1 | Set transmit underflow |
| txUdfClr | output | 1 | Clear transmit underflow |
| txRdySet | output | 1 | Set transmit ready |
| txRdyClr | output | 1 | Clear transmit ready |
| rxOvrSet | output | 1 | Set receive overrun |
| rxOvrClr | output | 1 | Clear receive overrun |
| rxRdySet | output | 1 | Set receive ready |
| rxRdyClr | output | 1 | Clear receive ready |
| sbdSet | output | 1 | Set single-byte data |

## Verification
The assertions check the count-related behaviour on every cycle:
- Both counts stay within `BYTES`.
- An underflow pulse only comes with an empty transmit side, and always together with a ready pulse.
- An overrun leaves the receive side full.
- A single-byte read, a receive-ready clear and a start all leave the relevant count at zero.

Only the bench scenarios can show the byte values themselves: transmit ordering under both byte orders, halfword assembly from received bytes, the exact acceptance limit for writes, and the priority between strobes arriving in the same cycle.

// File: rtl/pack_buf_pkg.sv
package pack_buf_pkg;
  // Buffer operation requested by the control for the current cycle.
  typedef struct packed {
    logic clear;  // zero every lane
    logic shl16;  // shift up two lanes, halfword enters lanes 1:0
    logic shl8;   // shift up one lane, byte enters lane 0
    logic shr16;  // shift down two lanes
    logic rxIns;  // write received byte into lane rxLane
  } bufCmd_t;
endpackage

// File: rtl/pack_buf_ctrl.sv
module pack_buf_ctrl
  import pack_buf_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startClr,
  input  logic             wrHalf,
  input  logic             wrByte,
  input  logic             rdHalf,
  input  logic             txTake,
  input  logic             rxPut,
  output bufCmd_t          cmd,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic             txUdfSet,
  output logic             txUdfClr,
  output logic             txRdySet,
  output logic             txRdyClr,
  output logic             rxOvrSet,
  output logic             rxOvrClr,
  output logic             rxRdySet,
  output logic             rxRdyClr,
  output logic             sbdSet
);
  localparam logic [CNT_W-1:0] TX_ROOM = CNT_W'(BYTES - 2);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTES);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] txD, rxD;
  logic selWrH, selWrB, selRd, selTake, selPut;
  logic txRoom;

  // fixed priority: start, halfword write, byte write, read, take, put
  assign selWrH  = wrHalf & ~startClr;
  assign selWrB  = wrByte & ~startClr & ~wrHalf;
  assign selRd   = rdHalf & ~startClr & ~wrHalf & ~wrByte;
  assign selTake = txTake & ~startClr & ~wrHalf & ~wrByte & ~rdHalf;
  assign selPut  = rxPut & ~startClr & ~wrHalf & ~wrByte & ~rdHalf & ~txTake;
  assign txRoom  = (txCnt <= TX_ROOM);

  always_comb begin
    cmd      = '0;
    txD      = txCnt;
    rxD      = rxCnt;
    txUdfSet = 1'b0;
    txUdfClr = 1'b0;
    txRdySet = 1'b0;
    txRdyClr = 1'b0;
    rxOvrSet = 1'b0;
    rxOvrClr = 1'b0;
    rxRdySet = 1'b0;
    rxRdyClr = 1'b0;
    sbdSet   = 1'b0;
    if (startClr) begin
      cmd.clear = 1'b1;
      txD = '0;
      rxD = '0;
    end else if (selWrH) begin
      if (txRoom) begin
        cmd.shl16 = 1'b1;
        txD       = txCnt + TWO;
        txUdfClr  = 1'b1;
        txRdyClr  = (txCnt != '0);
      end
    end else if (selWrB) begin
      if (txRoom) begin
        cmd.shl8 = 1'b1;
        txD      = txCnt + ONE;
        txUdfClr = 1'b1;
        txRdyClr = (txCnt >= TWO);
      end
    end else if (selRd) begin
      rxOvrClr = 1'b1;
      if (rxCnt == ONE) begin
        sbdSet = 1'b1;
        rxD    = '0;
      end else if (rxCnt > ONE) begin
        cmd.shr16 = (rxCnt > TWO);
        rxD       = rxCnt - TWO;
      end
      rxRdyClr = (rxD == '0);
    end else if (selTake) begin
      txRdySet = 1'b1;
      if (txCnt != '0) txD = txCnt - ONE;
      else             txUdfSet = 1'b1;
    end else if (selPut) begin
      rxRdySet = 1'b1;
      if (rxCnt < FULL) begin
        cmd.rxIns = 1'b1;
        rxD       = rxCnt + ONE;
      end else begin
        rxOvrSet = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      txCnt <= txD;
      rxCnt <= rxD;
    end
  end
endmodule

// File: rtl/pack_buf_data.sv
module pack_buf_data
  import pack_buf_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufCmd_t          cmd,
  input  logic             bigEnd,
  input  logic [15:0]      wrData,
  input  logic [7:0]       rxByte,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  output logic [7:0]       txByte,
  output logic [15:0]      rdData
);
  logic [7:0]  laneQ [BYTES];
  logic [7:0]  laneD [BYTES];
  logic [15:0] halfIn;

  // byte order on entry: swap unless big-endian
  assign halfIn = bigEnd ? wrData : {wrData[7:0], wrData[15:8]};

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [7:0] upTwo, upOne, downTwo;
    if (i >= 2) begin : g_up2
      assign upTwo = laneQ[i-2];
    end else begin : g_in2
      assign upTwo = halfIn[i*8 +: 8];
    end
    if (i >= 1) begin : g_up1
      assign upOne = laneQ[i-1];
    end else begin : g_in1
      assign upOne = wrData[7:0];
    end
    if (i + 2 < BYTES) begin : g_dn2
      assign downTwo = laneQ[i+2];
    end else begin : g_dn0
      assign downTwo = 8'h00;
    end
    always_comb begin
      laneD[i] = laneQ[i];
      if (cmd.clear)                                   laneD[i] = 8'h00;
      else if (cmd.shl16)                              laneD[i] = upTwo;
      else if (cmd.shl8)                               laneD[i] = upOne;
      else if (cmd.shr16)                              laneD[i] = downTwo;
      else if (cmd.rxIns && rxCnt == CNT_W'(i))        laneD[i] = rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BYTES; i++) laneQ[i] <= 8'h00;
    end else begin
      for (int i = 0; i < BYTES; i++) laneQ[i] <= laneD[i];
    end
  end

  always_comb begin
    txByte = 8'h00;
    for (int i = 0; i < BYTES; i++)
      if (txCnt == CNT_W'(i + 1)) txByte = laneQ[i];
  end

  assign rdData = bigEnd ? {laneQ[0], laneQ[1]} : {laneQ[1], laneQ[0]};
endmodule

// File: rtl/pack_buf.sv
module pack_buf
  import pack_buf_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bigEnd,
  input  logic        startClr,
  input  logic        wrHalf,
  input  logic        wrByte,
  input  logic [15:0] wrData,
  input  logic        rdHalf,
  output logic [15:0] rdData,
  input  logic        txTake,
  output logic [7:0]  txByte,
  input  logic        rxPut,
  input  logic [7:0]  rxByte,
  output logic        txUdfSet,
  output logic        txUdfClr,
  output logic        txRdySet,
  output logic        txRdyClr,
  output logic        rxOvrSet,
  output logic        rxOvrClr,
  output logic        rxRdySet,
  output logic        rxRdyClr,
  output logic        sbdSet
);
  bufCmd_t          cmd;
  logic [CNT_W-1:0] txCnt, rxCnt;

  pack_buf_ctrl #(.BYTES(BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startClr(startClr), .wrHalf(wrHalf),
    .wrByte(wrByte), .rdHalf(rdHalf), .txTake(txTake), .rxPut(rxPut),
    .cmd(cmd), .txCnt(txCnt), .rxCnt(rxCnt),
    .txUdfSet(txUdfSet), .txUdfClr(txUdfClr), .txRdySet(txRdySet),
    .txRdyClr(txRdyClr), .rxOvrSet(rxOvrSet), .rxOvrClr(rxOvrClr),
    .rxRdySet(rxRdySet), .rxRdyClr(rxRdyClr), .sbdSet(sbdSet)
  );

  pack_buf_data #(.BYTES(BYTES), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bigEnd(bigEnd), .wrData(wrData),
    .rxByte(rxByte), .txCnt(txCnt), .rxCnt(rxCnt),
    .txByte(txByte), .rdData(rdData)
  );
endmodule

// File: rtl/pack_buf_chk.sv
module pack_buf_chk #(
  parameter int BYTES = 4,
  parameter int CNT_W = $clog2(BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startClr,
  input logic             txUdfSet,
  input logic             txRdySet,
  input logic             rxOvrSet,
  input logic             rxRdyClr,
  input logic             sbdSet,
  input logic [CNT_W-1:0] txCnt,
  input logic [CNT_W-1:0] rxCnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTES);

  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCnt <= FULL);
  // R7
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= FULL);
  // R5
  udf_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUdfSet |-> (txCnt == '0));
  // R5
  udf_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUdfSet |-> txRdySet);
  // R7
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOvrSet |=> (rxCnt == FULL));
  // R8
  sbd_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    sbdSet |=> (rxCnt == '0));
  // R9
  rdy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxRdyClr |=> (rxCnt == '0));
  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startClr |=> (txCnt == '0 && rxCnt == '0));
endmodule

bind pack_buf pack_buf_chk #(.BYTES(BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .startClr(startClr), .txUdfSet(txUdfSet),
  .txRdySet(txRdySet), .rxOvrSet(rxOvrSet), .rxRdyClr(rxRdyClr),
  .sbdSet(sbdSet), .txCnt(txCnt), .rxCnt(rxCnt)
);

// File: tb/tb_pack_buf.sv
module tb_pack_buf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bigEnd = 1'b0, startClr = 1'b0, wrHalf = 1'b0, wrByte = 1'b0;
  logic rdHalf = 1'b0, txTake = 1'b0, rxPut = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  rxByte = '0;
  logic [15:0] rdData;
  logic [7:0]  txByte;
  logic txUdfSet, txUdfClr, txRdySet, txRdyClr;
  logic rxOvrSet, rxOvrClr, rxRdySet, rxRdyClr, sbdSet;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [8:0]  ev;
  logic [7:0]  sTx;
  logic [15:0] sRd;

  always #2 clk = ~clk;

  pack_buf dut (
    .clk(clk), .rstN(rstN), .bigEnd(bigEnd), .startClr(startClr),
    .wrHalf(wrHalf), .wrByte(wrByte), .wrData(wrData), .rdHalf(rdHalf),
    .rdData(rdData), .txTake(txTake), .txByte(txByte), .rxPut(rxPut),
    .rxByte(rxByte), .txUdfSet(txUdfSet), .txUdfClr(txUdfClr),
    .txRdySet(txRdySet), .txRdyClr(txRdyClr), .rxOvrSet(rxOvrSet),
    .rxOvrClr(rxOvrClr), .rxRdySet(rxRdySet), .rxRdyClr(rxRdyClr),
    .sbdSet(sbdSet)
  );

  // event vector bits
  localparam int E_UDFS = 8, E_UDFC = 7, E_TRS = 6, E_TRC = 5;
  localparam int E_OVRS = 4, E_OVRC = 3, E_RRS = 2, E_RRC = 1, E_SBD = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: drive after the falling edge, sample before the rising edge
  task automatic op(input logic wh, input logic wb, input logic rd, input logic tk,
                    input logic pt, input logic st, input logic [15:0] d, input logic [7:0] rb);
    @(negedge clk);
    wrHalf = wh; wrByte = wb; rdHalf = rd; txTake = tk; rxPut = pt; startClr = st;
    wrData = d; rxByte = rb;
    #1;
    ev  = {txUdfSet, txUdfClr, txRdySet, txRdyClr, rxOvrSet, rxOvrClr, rxRdySet, rxRdyClr, sbdSet};
    sTx = txByte;
    sRd = rdData;
    @(posedge clk);
    #1;
    wrHalf = 0; wrByte = 0; rdHalf = 0; txTake = 0; rxPut = 0; startClr = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp [8];
    logic [7:0] rb [6];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 events idle", {7'd0, txUdfSet, txUdfClr, txRdySet, txRdyClr, rxOvrSet,
        rxOvrClr, rxRdySet, rxRdyClr, sbdSet}, 16'h0);
    chk("R1 txByte", {8'h0, txByte}, 16'h0);
    chk("R1 rdData", rdData, 16'h0);
    op(0,0,0,1,0,0,16'h0,8'h0);
    chk("R1 empty take underflow", {15'd0, ev[E_UDFS]}, 16'h1);

    // transmit sweep: R2 R3 R4 R5 R6
    for (int be = 0; be < 2; be++) begin
      for (int nh = 0; nh < 4; nh++) begin
        for (int ab = 0; ab < 2; ab++) begin
          int cnt;
          int acc;
          bigEnd = be[0];
          op(0,0,0,0,0,1,16'h0,8'h0);
          cnt = 0;
          for (int k = 0; k < nh; k++) begin
            logic [7:0] hi, lo;
            hi = 8'hA0 + 8'(k) + 8'(16 * nh);
            lo = 8'h50 + 8'(k) + 8'(16 * ab);
            acc = (cnt <= 2) ? 1 : 0;
            op(1,0,0,0,0,0,{hi, lo},8'h0);
            chk("R2 R6 half accept udfClr", {15'd0, ev[E_UDFC]}, 16'(acc));
            chk("R6 half rdyClr", {15'd0, ev[E_TRC]}, 16'((acc == 1 && cnt + 2 > 2) ? 1 : 0));
            if (acc == 1) begin
              exp[cnt]   = be ? hi : lo;
              exp[cnt+1] = be ? lo : hi;
              cnt += 2;
            end
          end
          if (ab == 1) begin
            logic [7:0] bb;
            bb = 8'hC0 + 8'(nh);
            acc = (cnt <= 2) ? 1 : 0;
            op(0,1,0,0,0,0,{8'hEE, bb},8'h0);
            chk("R3 byte accept udfClr", {15'd0, ev[E_UDFC]}, 16'(acc));
            chk("R6 byte rdyClr", {15'd0, ev[E_TRC]}, 16'((acc == 1 && cnt + 1 > 2) ? 1 : 0));
            if (acc == 1) begin
              exp[cnt] = bb;
              cnt += 1;
            end
          end
          for (int j = 0; j <= cnt; j++) begin
            op(0,0,0,1,0,0,16'h0,8'h0);
            chk("R4 tx byte order", {8'h0, sTx}, {8'h0, (j < cnt) ? exp[j] : 8'h00});
            chk("R5 underflow", {15'd0, ev[E_UDFS]}, 16'((j == cnt) ? 1 : 0));
            chk("R5 ready set", {15'd0, ev[E_TRS]}, 16'h1);
          end
        end
      end
    end

    // receive sweep: R7 R8 R9
    for (int be = 0; be < 2; be++) begin
      for (int n = 0; n < 6; n++) begin
        int held;
        int idx;
        bigEnd = be[0];
        op(0,0,0,0,0,1,16'h0,8'h0);
        for (int k = 0; k < n; k++) begin
          rb[k] = 8'h30 + 8'(k) + 8'(16 * n) + 8'(be * 8);
          op(0,0,0,0,1,0,16'h0,rb[k]);
          chk("R7 rx ready set", {15'd0, ev[E_RRS]}, 16'h1);
          chk("R7 rx overrun", {15'd0, ev[E_OVRS]}, 16'((k >= 4) ? 1 : 0));
        end
        held = (n > 4) ? 4 : n;
        idx = 0;
        if (held == 0) begin
          op(0,0,1,0,0,0,16'h0,8'h0);
          chk("R8 empty read no sbd", {15'd0, ev[E_SBD]}, 16'h0);
          chk("R9 empty read rdyClr", {15'd0, ev[E_RRC]}, 16'h1);
          chk("R9 ovrClr", {15'd0, ev[E_OVRC]}, 16'h1);
        end
        while (held > 0) begin
          op(0,0,1,0,0,0,16'h0,8'h0);
          chk("R9 ovrClr", {15'd0, ev[E_OVRC]}, 16'h1);
          if (held == 1) begin
            chk("R8 single byte sbd", {15'd0, ev[E_SBD]}, 16'h1);
            chk("R8 single byte data", {8'h0, be ? sRd[15:8] : sRd[7:0]}, {8'h0, rb[idx]});
            chk("R9 rdyClr last", {15'd0, ev[E_RRC]}, 16'h1);
            held = 0;
          end else begin
            chk("R8 pair data", sRd, be ? {rb[idx], rb[idx+1]} : {rb[idx+1], rb[idx]});
            chk("R8 pair no sbd", {15'd0, ev[E_SBD]}, 16'h0);
            held -= 2;
            idx += 2;
            chk("R9 rdyClr when drained", {15'd0, ev[E_RRC]}, 16'((held == 0) ? 1 : 0));
          end
        end
      end
    end

    // R10 start zeroes data and counts
    bigEnd = 1'b0;
    op(1,0,0,0,0,0,16'hABCD,8'h0);
    op(0,0,0,0,1,0,16'h0,8'h77);
    op(0,0,0,0,0,1,16'h0,8'h0);
    op(0,0,1,0,0,0,16'h0,8'h0);
    chk("R10 data cleared", sRd, 16'h0);
    chk("R10 rx count cleared", {15'd0, ev[E_SBD]}, 16'h0);
    op(0,0,0,1,0,0,16'h0,8'h0);
    chk("R10 tx count cleared", {15'd0, ev[E_UDFS]}, 16'h1);

    // R11 priority: write wins over put, put has no effect
    op(0,0,0,0,0,1,16'h0,8'h0);
    op(1,0,0,0,1,0,16'h1234,8'h99);
    chk("R11 put suppressed", {15'd0, ev[E_RRS]}, 16'h0);
    chk("R11 write taken", {15'd0, ev[E_UDFC]}, 16'h1);
    op(0,0,1,0,0,0,16'h0,8'h0);
    chk("R11 rx count untouched", {15'd0, ev[E_SBD]}, 16'h0);
    // read beats take: transmit count stays 2
    op(0,0,1,1,0,0,16'h0,8'h0);
    chk("R11 take suppressed", {15'd0, ev[E_TRS]}, 16'h0);
    op(0,0,0,1,0,0,16'h0,8'h0);
    chk("R11 tx byte kept", {8'h0, sTx}, 16'h0034);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule